// File: doc/BRIEF.md
# Serial Expansion Bus Master

This block is a single-channel master for a four-wire serial expansion bus. A host reaches it through three 32-bit registers. The status register picks which device select line is driven and how fast the shift clock runs, and it holds a sticky completion flag. The control register starts a burst and sets its direction and its length. The data register holds up to four bytes: bytes to transmit, or bytes received at the end of a read.

Each transfer is one programmed burst of 1 to 4 bytes. Bits go out MSB first in clock mode 0: the clock idles low, the slave samples on the rising edge, and the data line changes on the falling edge. The shift clock is divided from the system clock by a power-of-two divider that the clock field selects. Device select lines follow the status register directly. Software can therefore keep one device selected across several bursts and release it by writing zero to the status register. When a burst ends, the start bit drops and the completion flag rises. The flag also drives an interrupt output, and stays high until the host writes a one to it.

Top module: `serx_master`

## Requirements
- R1: After reset all three registers read 0, every device select (`csN`) is high, and `sclk`, `mosi` and `irq` are low.
- R2: Status bits 9:7 form the device field. `csN[k]` is the inverse of status bit 7+k, so setting bit 8 selects device 1 alone. Writing 0 to the status register deasserts every select. The status register reads back bits 9:7 and 6:4 as written, with the flag at bit 3.
- R3: Status bits 6:4 are the clock code. For code c from 0 to 5, each half period of `sclk` lasts BASE_HALF·2^(5−c) system cycles. Codes 6 and 7 act as code 0. `sclk` idles low, and its first rising edge comes one half period after the start write.
- R4: A control write (offset 12) with bit 0 = 1 and bit 1 = 0, made while idle, starts a burst of (bits 5:4)+1 bytes with exactly 8 rising `sclk` edges per byte. If bit 1 = 1 the start is ignored: no `sclk` edge and no flag.
- R5: Type field control bits 3:2. Codes 01 and 11 are write bursts: `mosi` carries the data register from bit 31 downward, one bit per clock. A write burst leaves the data register unchanged. `mosi` is stable while `sclk` is high.
- R6: Type 00 is a read: `mosi` stays low, and at the end the received bits are placed left-aligned in the data register with the unused low bits zero. Type 10 both transmits as in R5 and receives as in R6.
- R7: The last falling `sclk` edge comes 2·H·8·n system cycles after the start write (H = half period, n = bytes). At that edge the flag (status bit 3) and `irq` are set and control bit 0 reads 0. Writing 1 to status bit 3 clears the flag. Writing 0 to it leaves the flag set.
- R8: While a burst runs, host writes to all three registers are ignored, and `csN` does not change.
- R9: The device select stays asserted between consecutive bursts until the status register is rewritten.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Host write strobe |
| addr | input | 5 | Host byte offset (0 status, 12 control, 16 data) |
| wrData | input | 32 | Host write data |
| rdData | output | 32 | Host read data, combinational on `addr` |
| csN | output | 3 | Active-low device selects |
| sclk | output | 1 | Serial shift clock, idle low |
| mosi | output | 1 | Serial data to devices |
| miso | input | 1 | Serial data from devices |
| irq | output | 1 | Completion flag |

## Verification
The start write at clock edge E loads the divider. `sclk` rises at edge E+H, so the bench checks it low after edge E+H−1 and high after edge E+H. The flag is due at edge E+2·H·8·n: it is checked clear one cycle before that edge and set one cycle after, so an off-by-one in the divider or the bit counter is caught. Register readback and select lines are sampled on the falling clock edge after the write edge. Bytes received and transmitted are checked against a bench slave model once the flag has risen.

// File: rtl/serx_pkg.sv
package serx_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 5;
  localparam int NUM_DEV = 3;

  localparam logic [ADDR_W-1:0] ADDR_STATUS = 5'd0;
  localparam logic [ADDR_W-1:0] ADDR_CTRL   = 5'd12;
  localparam logic [ADDR_W-1:0] ADDR_DATA   = 5'd16;

  // status field positions
  localparam int ST_FLAG = 3;
  localparam int ST_CLK_LO = 4;
  localparam int ST_DEV_LO = 7;

  // control field positions
  localparam int CT_START = 0;
  localparam int CT_MODE = 1;
  localparam int CT_TYPE_LO = 2;
  localparam int CT_LEN_LO = 4;

  localparam logic [1:0] XFER_READ = 2'b00;

  typedef struct packed {
    logic load;
    logic rise;
    logic fall;
    logic finish;
  } serx_strobe_t;
endpackage

// File: rtl/serx_ctrl.sv
module serx_ctrl
  import serx_pkg::*;
#(
  parameter int BASE_HALF = 1
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         startReq,
  input  logic [2:0]   clkCode,
  input  logic [1:0]   byteLen,
  output serx_strobe_t strobe,
  output logic         busy,
  output logic         sclk
);
  localparam int HALF_MAX = BASE_HALF * 32;
  localparam int CNT_W = $clog2(HALF_MAX + 1);
  localparam int BIT_W = 5;

  logic [CNT_W-1:0] divCnt;
  logic [CNT_W-1:0] halfLen;
  logic [BIT_W-1:0] bitCnt;
  logic [BIT_W-1:0] lastBit;
  logic             tick;

  function automatic logic [CNT_W-1:0] halfCycles(input logic [2:0] code);
    logic [2:0] eff;
    eff = (code > 3'd5) ? 3'd0 : code;
    return CNT_W'(BASE_HALF) << (3'd5 - eff);
  endfunction

  assign halfLen = halfCycles(clkCode);
  assign tick = busy && (divCnt == '0);

  always_comb begin
    strobe.load   = startReq && !busy;
    strobe.rise   = tick && !sclk;
    strobe.fall   = tick && sclk;
    strobe.finish = tick && sclk && (bitCnt == lastBit);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy    <= 1'b0;
      sclk    <= 1'b0;
      divCnt  <= '0;
      bitCnt  <= '0;
      lastBit <= '0;
    end else if (strobe.load) begin
      busy    <= 1'b1;
      sclk    <= 1'b0;
      divCnt  <= halfLen - 1'b1;
      bitCnt  <= '0;
      lastBit <= {byteLen, 3'b111};
    end else if (busy) begin
      if (tick) begin
        divCnt <= halfLen - 1'b1;
        sclk   <= ~sclk;
        if (strobe.finish) begin
          busy <= 1'b0;
        end else if (strobe.fall) begin
          bitCnt <= bitCnt + 1'b1;
        end
      end else begin
        divCnt <= divCnt - 1'b1;
      end
    end
  end
endmodule

// File: rtl/serx_datapath.sv
module serx_datapath
  import serx_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  serx_strobe_t      strobe,
  input  logic              busy,
  output logic              startReq,
  output logic [2:0]        clkCode,
  output logic [1:0]        byteLen,
  output logic [NUM_DEV-1:0] csN,
  output logic              mosi,
  input  logic              miso,
  output logic              irq
);
  logic [NUM_DEV-1:0] devSel;
  logic [2:0]         clkSel;
  logic               doneFlag;
  logic [1:0]         lenSel;
  logic [1:0]         typeSel;
  logic               modeSel;
  logic [DATA_W-1:0]  dataReg;
  logic [DATA_W-1:0]  txShift;
  logic [DATA_W-1:0]  rxAcc;
  logic               wrStatus;
  logic               wrCtrl;
  logic               wrDataReg;
  logic               txEn;
  logic               rxEn;
  logic [4:0]         alignShift;

  assign wrStatus  = wrEn && (addr == ADDR_STATUS) && !busy;
  assign wrCtrl    = wrEn && (addr == ADDR_CTRL) && !busy;
  assign wrDataReg = wrEn && (addr == ADDR_DATA) && !busy;
  assign startReq  = wrCtrl && wrData[CT_START] && !wrData[CT_MODE];

  assign clkCode = clkSel;
  assign byteLen = wrCtrl ? wrData[CT_LEN_LO +: 2] : lenSel;
  assign irq     = doneFlag;

  assign txEn       = (typeSel != XFER_READ);
  assign rxEn       = !typeSel[0];
  assign alignShift = {2'd3 - lenSel, 3'b000};
  assign mosi       = busy && txEn && txShift[DATA_W-1];

  for (genvar i = 0; i < NUM_DEV; i++) begin : g_sel
    assign csN[i] = ~devSel[i];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      devSel   <= '0;
      clkSel   <= '0;
      doneFlag <= 1'b0;
    end else begin
      if (wrStatus) begin
        devSel <= wrData[ST_DEV_LO +: NUM_DEV];
        clkSel <= wrData[ST_CLK_LO +: 3];
      end
      if (strobe.finish) begin
        doneFlag <= 1'b1;
      end else if (wrStatus && wrData[ST_FLAG]) begin
        doneFlag <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lenSel  <= '0;
      typeSel <= '0;
      modeSel <= 1'b0;
    end else if (wrCtrl) begin
      lenSel  <= wrData[CT_LEN_LO +: 2];
      typeSel <= wrData[CT_TYPE_LO +: 2];
      modeSel <= wrData[CT_MODE];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataReg <= '0;
      txShift <= '0;
      rxAcc   <= '0;
    end else begin
      if (wrDataReg) begin
        dataReg <= wrData;
      end else if (strobe.finish && rxEn) begin
        dataReg <= rxAcc << alignShift;
      end
      if (strobe.load) begin
        txShift <= dataReg;
        rxAcc   <= '0;
      end else begin
        if (strobe.fall && !strobe.finish) begin
          txShift <= {txShift[DATA_W-2:0], 1'b0};
        end
        if (strobe.rise) begin
          rxAcc <= {rxAcc[DATA_W-2:0], miso};
        end
      end
    end
  end

  always_comb begin
    rdData = '0;
    case (addr)
      ADDR_STATUS: begin
        rdData[ST_DEV_LO +: NUM_DEV] = devSel;
        rdData[ST_CLK_LO +: 3]       = clkSel;
        rdData[ST_FLAG]              = doneFlag;
      end
      ADDR_CTRL: begin
        rdData[CT_LEN_LO +: 2]  = lenSel;
        rdData[CT_TYPE_LO +: 2] = typeSel;
        rdData[CT_MODE]         = modeSel;
        rdData[CT_START]        = busy;
      end
      ADDR_DATA: rdData = dataReg;
      default: rdData = '0;
    endcase
  end
endmodule

// File: rtl/serx_master.sv
module serx_master
  import serx_pkg::*;
#(
  parameter int BASE_HALF = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic [NUM_DEV-1:0] csN,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic              irq
);
  serx_strobe_t strobe;
  logic         busy;
  logic         startReq;
  logic [2:0]   clkCode;
  logic [1:0]   byteLen;

  serx_ctrl #(.BASE_HALF(BASE_HALF)) u_ctrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .clkCode(clkCode),
    .byteLen(byteLen), .strobe(strobe), .busy(busy), .sclk(sclk)
  );

  serx_datapath u_dp (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .strobe(strobe), .busy(busy), .startReq(startReq),
    .clkCode(clkCode), .byteLen(byteLen), .csN(csN), .mosi(mosi),
    .miso(miso), .irq(irq)
  );
endmodule

// File: rtl/serx_checker.sv
module serx_checker (
  input logic       clk,
  input logic       rstN,
  input logic       busy,
  input logic       sclk,
  input logic       mosi,
  input logic [2:0] csN,
  input logic       irq
);
  AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !sclk); // R3
  AST_MOSI_IDLE_LOW: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !mosi); // R1
  AST_FLAG_AT_END: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> irq); // R7
  AST_SEL_HELD_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(csN)); // R8
  AST_MOSI_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (sclk && $past(sclk)) |-> $stable(mosi)); // R5
endmodule

bind serx_master serx_checker u_chk (
  .clk(clk), .rstN(rstN), .busy(busy), .sclk(sclk),
  .mosi(mosi), .csN(csN), .irq(irq)
);

// File: tb/serx_master_bench.sv
module serx_master_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [4:0]  addr = 5'd0;
  logic [31:0] wrData = 32'd0;
  logic [31:0] rdData;
  logic [2:0]  csN;
  logic        sclk;
  logic        mosi;
  logic        miso;
  logic        irq;

  int checkCount = 0;
  int failCount = 0;
  int pulseCount = 0;
  logic [31:0] slaveWord = 32'd0;
  logic [31:0] slaveRx = 32'd0;
  logic finished = 1'b0;

  always #5 clk = ~clk;

  serx_master u_serx_master (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .csN(csN), .sclk(sclk), .mosi(mosi), .miso(miso),
    .irq(irq)
  );

  assign miso = slaveWord[31];
  always @(negedge sclk) slaveWord = slaveWord << 1;
  always @(posedge sclk) begin
    slaveRx = {slaveRx[30:0], mosi};
    pulseCount = pulseCount + 1;
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checkCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic hostWrite(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(posedge clk);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic hostRead(input logic [4:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdData;
  endtask

  function automatic int halfOf(input int code);
    int eff;
    eff = (code > 5) ? 0 : code;
    return 1 << (5 - eff);
  endfunction

  function automatic logic [31:0] topMask(input int nBytes);
    return (nBytes == 4) ? 32'hFFFF_FFFF : ~(32'hFFFF_FFFF >> (8 * nBytes));
  endfunction

  task automatic runXfer(input logic [2:0] dev, input int code, input int len,
                         input logic [1:0] kind, input logic [31:0] txWord,
                         input logic [31:0] slaveW);
    int h;
    int t;
    int n;
    logic [31:0] rd;
    logic [31:0] expTx;
    logic [31:0] expData;
    n = len + 1;
    h = halfOf(code);
    t = 2 * h * 8 * n;
    hostWrite(5'd0, {22'd0, dev, 3'(code), 1'b1, 3'd0});
    hostWrite(5'd16, txWord);
    slaveWord = slaveW; slaveRx = 32'd0; pulseCount = 0;
    hostWrite(5'd12, {26'd0, 2'(len), kind, 1'b0, 1'b1});
    repeat (h - 1) @(negedge clk);
    check("R3 sclk low before first rise", {31'd0, sclk}, 32'd0);
    @(negedge clk);
    check("R3 sclk first rise", {31'd0, sclk}, 32'd1);
    repeat (t - h - 1) @(negedge clk);
    check("R7 flag clear before last edge", {31'd0, irq}, 32'd0);
    @(negedge clk);
    check("R7 flag set at last edge", {31'd0, irq}, 32'd1);
    check("R4 sclk pulse count", pulseCount, 32'(8 * n));
    expTx = (kind != 2'b00) ? (txWord >> (32 - 8 * n)) : 32'd0;
    if (n == 4) expTx = (kind != 2'b00) ? txWord : 32'd0;
    check((kind == 2'b00) ? "R6 mosi low on read" : "R5 mosi bits", slaveRx, expTx);
    expData = (kind[0] == 1'b0) ? (slaveW & topMask(n)) : txWord;
    hostRead(5'd16, rd);
    check((kind[0] == 1'b0) ? "R6 received left aligned" : "R5 data kept", rd, expData);
    hostRead(5'd12, rd);
    check("R7 start bit cleared", {31'd0, rd[0]}, 32'd0);
  endtask

  task automatic clearFlag(input logic [2:0] dev);
    logic [31:0] rd;
    hostRead(5'd0, rd);
    hostWrite(5'd0, {22'd0, dev, rd[6:4], 1'b1, 3'd0});
    check("R7 flag cleared by one", {31'd0, irq}, 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failCount++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1 reset state
    hostRead(5'd0, rd);  check("R1 status reset", rd, 32'd0);
    hostRead(5'd12, rd); check("R1 control reset", rd, 32'd0);
    hostRead(5'd16, rd); check("R1 data reset", rd, 32'd0);
    check("R1 selects high", {29'd0, csN}, 32'd7);
    check("R1 outputs low", {29'd0, sclk, mosi, irq}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);

    // R2 device field and readback
    hostWrite(5'd0, 32'h0000_0130);
    check("R2 device 1 selected", {29'd0, csN}, 32'd5);
    hostRead(5'd0, rd); check("R2 status readback", rd, 32'h0000_0130);
    hostWrite(5'd0, 32'h0000_0200);
    check("R2 device 2 selected", {29'd0, csN}, 32'd3);
    hostWrite(5'd0, 32'd0);
    check("R2 zero write deselects", {29'd0, csN}, 32'd7);

    // R4 start with mode bit set is ignored
    pulseCount = 0;
    hostWrite(5'd0, 32'h0000_0150);
    hostWrite(5'd12, 32'h0000_0037);
    repeat (100) @(negedge clk);
    check("R4 mode bit start no pulses", pulseCount, 32'd0);
    check("R4 mode bit start no flag", {31'd0, irq}, 32'd0);
    hostRead(5'd12, rd); check("R4 mode bit start not busy", {31'd0, rd[0]}, 32'd0);

    // R9 select held across two bursts
    runXfer(3'b010, 5, 0, 2'b01, 32'hA5C3_0000, 32'h0);
    check("R9 select held after burst", {29'd0, csN}, 32'd5);
    runXfer(3'b010, 4, 1, 2'b00, 32'h0, 32'h9E1F_7700);
    check("R9 select held after second burst", {29'd0, csN}, 32'd5);
    clearFlag(3'b010);
    check("R9 select kept by flag clear", {29'd0, csN}, 32'd5);

    // R7 writing zero to the flag bit keeps it
    runXfer(3'b001, 5, 3, 2'b10, 32'h1234_5678, 32'hCAFE_F00D);
    hostWrite(5'd0, 32'h0000_00D0);
    check("R7 flag kept by zero write", {31'd0, irq}, 32'd1);
    clearFlag(3'b001);

    // R8 writes during a burst are ignored
    hostWrite(5'd0, 32'h0000_0100);
    hostWrite(5'd16, 32'h8001_7FFE);
    slaveWord = 32'h0; slaveRx = 32'h0; pulseCount = 0;
    hostWrite(5'd12, 32'h0000_0035);
    repeat (20) @(negedge clk);
    hostWrite(5'd16, 32'hDEAD_BEEF);
    hostWrite(5'd0, 32'd0);
    hostWrite(5'd12, 32'h0000_0001);
    check("R8 select unchanged during burst", {29'd0, csN}, 32'd5);
    repeat (2100) @(negedge clk);
    hostRead(5'd16, rd); check("R8 data write ignored", rd, 32'h8001_7FFE);
    check("R8 transmitted original word", slaveRx, 32'h8001_7FFE);
    hostRead(5'd12, rd); check("R8 control write ignored", rd, 32'h0000_0034);
    clearFlag(3'b010);

    // random bursts, clock codes 0..7 (R3 codes 6,7 slow)
    for (int i = 0; i < 30; i++) begin
      int code;
      int len;
      logic [1:0] kind;
      code = int'($urandom_range(7, 0));
      len = int'($urandom_range(3, 0));
      kind = 2'($urandom_range(3, 0));
      runXfer(3'b010, code, len, kind, $urandom, $urandom);
      clearFlag(3'b010);
    end
    hostWrite(5'd0, 32'd0);
    check("R2 final deselect", {29'd0, csN}, 32'd7);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  end
endmodule